// File: doc/BRIEF.md
# Pixel Output Bus Formatter with Two-Device Bus Sharing

This block takes 16-bit pixel words from a converter, each arriving with a channel tag and a valid strobe, and places them on an 8-bit output bus at double data rate on the converter clock. The high byte is on the bus for the half cycle that follows each rising edge, and the low byte for the half cycle that follows the falling edge. A configuration bit can convert each word to its reflected Gray code before the split. A frame marker input, the sampling pulse, sets the start of the slot sequence that picks which channel word goes out on each clock.

In three-channel mode the words leave in channel order 0, 1, 2 and then repeat. In cascade mode two identical devices share one bus. The six-slot period after the marker is split into two halves. The device with ID 0 sends its three channel words in the first half and the device with ID 1 sends its words in the second half. In any slot a device does not own, it drops its output enable. In one-channel mode the newest word goes out on every clock and the cascade bit has no effect.

The controller has three states. IDLE covers power-down and reset. WAIT means the block is powered and has not yet seen a marker. RUN means slots are being issued. The transitions are: IDLE to WAIT when the power bit is set, WAIT to RUN when the marker is sampled, and from WAIT or RUN back to IDLE when the power bit is cleared. A marker sampled in RUN restarts the slot count at 0.

Top module: `pixel_bus_formatter`

## Requirements
- R1: While rst_n is low, bus_oe is 0 and bus_data is 0.
- R2: For the word chosen at a rising edge, bits 15:8 are on bus_data from that rising edge to the next falling edge. Bits 7:0 are on bus_data from that falling edge to the next rising edge.
- R3: With cfg_gray=1 the word sent is b ^ (b >> 1), so bit 15 is unchanged and bit i is b[i]^b[i+1]. With cfg_gray=0 the binary word is sent unchanged (0000h is black, FFFFh is white).
- R4: After power-up, no pixel data leaves until a frame_mark is sampled high. If frame_mark is high at rising edge k, slot 0 is issued at edge k+1, whatever state the block is in.
- R5: In three-channel normal mode (cfg_one_ch=0, cfg_casc=0), slots 0, 1 and 2 send the stored words of channels 0, 1 and 2, and the slots then repeat. A word with pix_valid=1 is stored under its pix_chan tag. Tag 3 is discarded.
- R6: In three-channel cascade mode, slots 0 to 5 repeat. Slots 0 to 2 carry channels 0 to 2 and belong to device ID 0. Slots 3 to 5 carry channels 0 to 2 and belong to device ID 1. In a slot it does not own, a device has bus_oe=0 and bus_data=0.
- R7: With cfg_one_ch=1, every clock in RUN sends the newest word, whatever the pix_chan tag. cfg_casc is ignored and bus_oe stays 1.
- R8: With cfg_pwr=0, the block goes back to IDLE. In IDLE it drives zeros with bus_oe=1 when the effective cascade mode is off, and it releases the bus (bus_oe=0, bus_data=0) when the effective cascade mode is on.
- R9: A word accepted at rising edge k can be sent in a slot that starts at edge k+1 or later. A slot that starts at edge k itself sends the previously stored word.
- R10: bus_oe changes only at rising edges and stays the same across the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwr | input | 1 | 1 = operating, 0 = powered down |
| cfg_gray | input | 1 | 1 = convert to Gray code before the split |
| cfg_casc | input | 1 | 1 = share the bus with a second device |
| cfg_dev_id | input | 1 | Slot half this device owns in cascade mode |
| cfg_one_ch | input | 1 | 1 = one-channel mode |
| frame_mark | input | 1 | Sampling pulse that restarts the slot count |
| pix_valid | input | 1 | A pixel word is present this cycle |
| pix_chan | input | 2 | Channel tag of the pixel word |
| pix_data | input | 16 | Pixel word, straight binary |
| bus_data | output | 8 | Double-rate byte bus |
| bus_oe | output | 1 | Bus output enable |

## Verification
The bench builds the block with its default values: 16-bit words, three channels and therefore a six-slot cascade period. This keeps every slot of both cascade halves, both device IDs and every channel tag, including the discarded tag 3, small enough to sweep completely. In one-channel mode the bench streams 256 generated words through each output format, checking both bytes of each word on both clock halves against Gray and binary values it computes arithmetically. It also moves through power-down, waiting and running with the cascade bit on and off, so both idle bus behaviours and the restart of the slot count on each marker are reached.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } pbf_state_e;

endpackage

// File: rtl/pbf_word_store.sv
module pbf_word_store #(
    parameter int DATA_W = 16,
    parameter int NCH    = 3,
    parameter int TAG_W  = 2,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              one_ch,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] ent_q [NCH];

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ent
        logic hit;
        assign hit = wr_en && (one_ch ? (gi == 0) : (wr_tag == TAG_W'(gi)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent_q[gi] <= '0;
            else if (hit) ent_q[gi] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_idx == SLOT_W'(i)) rd_data = ent_q[i];
        end
    end

endmodule

// File: rtl/pbf_slot_fsm.sv
module pbf_slot_fsm
    import pbf_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr,
    input  logic              mark,
    input  logic              casc_eff,
    input  logic              one_ch,
    input  logic              dev_id,
    output logic              drive,
    output logic              oe_next,
    output logic [SLOT_W-1:0] rd_idx
);

    localparam logic [SLOT_W-1:0] LAST_CASC = SLOT_W'(2 * NCH - 1);
    localparam logic [SLOT_W-1:0] LAST_NORM = SLOT_W'(NCH - 1);
    localparam logic [SLOT_W-1:0] HALF      = SLOT_W'(NCH);

    pbf_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d, last_slot;

    always_comb begin
        if (one_ch)        last_slot = '0;
        else if (casc_eff) last_slot = LAST_CASC;
        else               last_slot = LAST_NORM;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pwr)  state_d = ST_WAIT;
            ST_WAIT: if (!pwr) state_d = ST_IDLE;
                     else if (mark) state_d = ST_RUN;
            ST_RUN:  if (!pwr) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (mark)                   slot_d = '0;
        else if (state_q != ST_RUN) slot_d = slot_q;
        else if (slot_q >= last_slot) slot_d = '0;
        else                        slot_d = slot_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    always_comb begin
        drive   = 1'b0;
        oe_next = !casc_eff;
        rd_idx  = '0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                drive   = 1'b0;
                oe_next = !casc_eff;
            end
            ST_RUN: begin
                if (one_ch) begin
                    drive   = 1'b1;
                    oe_next = 1'b1;
                    rd_idx  = '0;
                end else if (casc_eff) begin
                    drive   = ((slot_q >= HALF) == dev_id);
                    oe_next = drive;
                    rd_idx  = (slot_q >= HALF) ? slot_q - HALF : slot_q;
                end else begin
                    drive   = 1'b1;
                    oe_next = 1'b1;
                    rd_idx  = slot_q;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pbf_ddr_out.sv
module pbf_ddr_out #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic              oe_next,
    output logic [BYTE_W-1:0] q,
    output logic              oe
);

    logic [BYTE_W-1:0] rise_q, fall_q, lo_hold_q;
    logic              oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q    <= '0;
            lo_hold_q <= '0;
            oe_q      <= 1'b0;
        end else begin
            rise_q    <= hi_byte ^ fall_q;
            lo_hold_q <= lo_byte;
            oe_q      <= oe_next;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= lo_hold_q ^ rise_q;
    end

    assign q  = rise_q ^ fall_q;
    assign oe = oe_q;

endmodule

// File: rtl/pixel_bus_formatter.sv
module pixel_bus_formatter #(
    parameter int DATA_W = 16,
    parameter int NCH    = 3,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pwr,
    input  logic              cfg_gray,
    input  logic              cfg_casc,
    input  logic              cfg_dev_id,
    input  logic              cfg_one_ch,
    input  logic              frame_mark,
    input  logic              pix_valid,
    input  logic [TAG_W-1:0]  pix_chan,
    input  logic [DATA_W-1:0] pix_data,
    output logic [DATA_W/2-1:0] bus_data,
    output logic              bus_oe
);

    localparam int BYTE_W = DATA_W / 2;
    localparam int SLOT_W = $clog2(2 * NCH);

    logic              casc_eff, drive, oe_next;
    logic [SLOT_W-1:0] rd_idx;
    logic [DATA_W-1:0] rd_data, coded, sent;

    assign casc_eff = cfg_casc && !cfg_one_ch;

    pbf_word_store #(
        .DATA_W(DATA_W), .NCH(NCH), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(pix_valid), .wr_tag(pix_chan),
        .wr_data(pix_data), .one_ch(cfg_one_ch), .rd_idx(rd_idx),
        .rd_data(rd_data)
    );

    pbf_slot_fsm #(
        .NCH(NCH), .SLOT_W(SLOT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr(cfg_pwr), .mark(frame_mark),
        .casc_eff(casc_eff), .one_ch(cfg_one_ch), .dev_id(cfg_dev_id),
        .drive(drive), .oe_next(oe_next), .rd_idx(rd_idx)
    );

    assign coded = cfg_gray ? (rd_data ^ (rd_data >> 1)) : rd_data;
    assign sent  = drive ? coded : '0;

    pbf_ddr_out #(
        .BYTE_W(BYTE_W)
    ) u_ddr (
        .clk(clk), .rst_n(rst_n), .hi_byte(sent[DATA_W-1:BYTE_W]),
        .lo_byte(sent[BYTE_W-1:0]), .oe_next(oe_next),
        .q(bus_data), .oe(bus_oe)
    );

endmodule

// File: rtl/pbf_checker.sv
module pbf_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_pwr,
    input logic              cfg_casc,
    input logic              cfg_one_ch,
    input logic [BYTE_W-1:0] bus_data,
    input logic              bus_oe
);

    logic [1:0] up_q;
    logic       oe_first_q;
    logic       casc_off;

    assign casc_off = cfg_casc && !cfg_one_ch && !cfg_pwr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          up_q <= '0;
        else if (up_q != 2'd3) up_q <= up_q + 2'd1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) oe_first_q <= 1'b0;
        else        oe_first_q <= bus_oe;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!bus_oe && bus_data == '0));

    p_released_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));

    p_one_ch_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q != 2'd0) && $past(cfg_one_ch) |-> bus_oe);

    p_normal_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q != 2'd0) && $past(!cfg_casc) |-> bus_oe);

    p_casc_down_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q >= 2'd2) && $past(casc_off) && $past(casc_off, 2) |-> !bus_oe);

    p_oe_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q >= 2'd2) |-> (bus_oe == oe_first_q));

endmodule

bind pixel_bus_formatter pbf_checker #(.BYTE_W(DATA_W / 2)) u_pbf_checker (
    .clk(clk), .rst_n(rst_n), .cfg_pwr(cfg_pwr), .cfg_casc(cfg_casc),
    .cfg_one_ch(cfg_one_ch), .bus_data(bus_data), .bus_oe(bus_oe)
);

// File: tb/test_pixel_bus_formatter.sv
module test_pixel_bus_formatter;

    localparam int CLK_PERIOD = 20;
    localparam int Q = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pwr = 1'b0, cfg_gray = 1'b0, cfg_casc = 1'b0;
    logic        cfg_dev_id = 1'b0, cfg_one_ch = 1'b0;
    logic        frame_mark = 1'b0, pix_valid = 1'b0;
    logic [1:0]  pix_chan = '0;
    logic [15:0] pix_data = '0;
    logic [7:0]  bus_data;
    logic        bus_oe;

    int errs = 0, checks = 0;
    bit done = 0;

    // independent behavioural model
    int          m_state = 0; // 0 idle, 1 wait, 2 run
    int          m_slot = 0;
    logic [15:0] m_buf [3] = '{16'h0, 16'h0, 16'h0};

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_bus_formatter i_pixel_bus_formatter (
        .clk(clk), .rst_n(rst_n), .cfg_pwr(cfg_pwr), .cfg_gray(cfg_gray),
        .cfg_casc(cfg_casc), .cfg_dev_id(cfg_dev_id), .cfg_one_ch(cfg_one_ch),
        .frame_mark(frame_mark), .pix_valid(pix_valid), .pix_chan(pix_chan),
        .pix_data(pix_data), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got oe/data %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag);
        logic        ce, oe, own;
        logic [15:0] w;
        int          ch, last;
        @(posedge clk);
        ce = cfg_casc && !cfg_one_ch;
        w = '0;
        if (m_state != 2) oe = !ce;
        else if (cfg_one_ch) begin oe = 1'b1; w = m_buf[0]; end
        else if (ce) begin
            own = ((m_slot >= 3) == cfg_dev_id);
            ch = (m_slot >= 3) ? m_slot - 3 : m_slot;
            oe = own;
            if (own) w = m_buf[ch];
        end else begin
            oe = 1'b1;
            if (m_slot < 3) w = m_buf[m_slot];
        end
        if (cfg_gray) w = w ^ (w >> 1);
        if (pix_valid) begin
            if (cfg_one_ch) m_buf[0] = pix_data;
            else if (pix_chan < 3) m_buf[pix_chan] = pix_data;
        end
        last = cfg_one_ch ? 0 : (ce ? 5 : 2);
        if (frame_mark) m_slot = 0;
        else if (m_state == 2) m_slot = (m_slot >= last) ? 0 : m_slot + 1;
        case (m_state)
            0: if (cfg_pwr) m_state = 1;
            1: if (!cfg_pwr) m_state = 0; else if (frame_mark) m_state = 2;
            default: if (!cfg_pwr) m_state = 0;
        endcase
        #Q;
        check(tag, {bus_oe, bus_data}, {oe, w[15:8]});
        @(negedge clk);
        #Q;
        check("R2 low byte", {1'b0, bus_data}, {1'b0, w[7:0]});
        check("R10 oe held", {8'h0, bus_oe}, {8'h0, oe});
    endtask

    task automatic put(logic v, logic [1:0] c, logic [15:0] d, logic mk);
        pix_valid = v; pix_chan = c; pix_data = d; frame_mark = mk;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errs, checks + 1);
            $finish;
        end
    end

    initial begin
        // R1: reset quiet in both modes
        repeat (2) @(posedge clk);
        #Q check("R1", {bus_oe, bus_data}, 9'h0);
        cfg_casc = 1'b1;
        @(posedge clk); #Q check("R1", {bus_oe, bus_data}, 9'h0);
        cfg_casc = 1'b0;
        @(negedge clk); #Q rst_n = 1'b1;

        // R8: powered down, normal mode drives zeros
        step("R8"); step("R8");

        // R4: powered, words stored but nothing leaves before a marker
        cfg_pwr = 1'b1;
        put(1, 2'd0, 16'h1234, 0); step("R4");
        put(1, 2'd1, 16'hABCD, 0); step("R4");
        put(1, 2'd2, 16'h00FF, 0); step("R4");
        put(0, 2'd0, 16'h0, 0);    step("R4");

        // R5: marker, then channel order repeats
        put(0, 2'd0, 16'h0, 1); step("R4");
        put(0, 2'd0, 16'h0, 0);
        for (int i = 0; i < 7; i++) step("R5");
        // R5: tag 3 discarded
        put(1, 2'd3, 16'hDEAD, 0); step("R5");
        put(0, 2'd0, 16'h0, 0);
        for (int i = 0; i < 4; i++) step("R5");
        // R9: new word for channel 1 seen from next edge
        put(1, 2'd1, 16'h5A5A, 0); step("R9");
        put(0, 2'd0, 16'h0, 0);
        for (int i = 0; i < 4; i++) step("R9");
        // R3: Gray in three-channel mode, marker mid-run restarts slots
        cfg_gray = 1'b1;
        put(0, 2'd0, 16'h0, 1); step("R4");
        put(0, 2'd0, 16'h0, 0);
        for (int i = 0; i < 6; i++) step("R3");

        // R7 + R3: one-channel sweep, cascade bit must be ignored
        cfg_one_ch = 1'b1; cfg_casc = 1'b1;
        for (int f = 0; f < 2; f++) begin
            cfg_gray = f[0];
            put(1, 2'd2, 16'h0000, 1); step("R7");
            put(1, 2'd1, 16'hFFFF, 0); step("R3");
            for (int i = 0; i < 256; i++) begin
                put(1, 2'(i), 16'(i * 16'h0101) ^ 16'(i << 7) ^ 16'h8001, 0);
                step(f[0] ? "R3 gray" : "R3 binary");
            end
            put(0, 2'd0, 16'h0, 0); step("R7"); step("R7");
        end

        // R6: cascade, both IDs
        cfg_one_ch = 1'b0; cfg_gray = 1'b0;
        put(1, 2'd0, 16'hC0C0, 0); step("R6");
        put(1, 2'd1, 16'hC1C1, 0); step("R6");
        put(1, 2'd2, 16'hC2C2, 0); step("R6");
        for (int d = 0; d < 2; d++) begin
            cfg_dev_id = d[0];
            put(0, 2'd0, 16'h0, 1); step("R6");
            put(0, 2'd0, 16'h0, 0);
            for (int i = 0; i < 13; i++) step("R6");
        end

        // R8: cascade power-down releases; R4 after re-power
        cfg_pwr = 1'b0;
        for (int i = 0; i < 3; i++) step("R8");
        cfg_pwr = 1'b1;
        for (int i = 0; i < 3; i++) step("R4");
        put(0, 2'd0, 16'h0, 1); step("R4");
        put(0, 2'd0, 16'h0, 0);
        for (int i = 0; i < 7; i++) step("R6");
        // R8: normal mode power-down after run
        cfg_casc = 1'b0; cfg_pwr = 1'b0;
        for (int i = 0; i < 3; i++) step("R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule